// File: doc/BRIEF.md
# Four-Digit Seven-Segment Scan Controller

This peripheral drives a four-digit multiplexed seven-segment display with no help from software. A host writes one 32-bit word that holds four hexadecimal digit values. The block then scans the display: a refresh timer marks fixed-length slots, and a digit pointer walks a one-hot anode select across the four digits. In every slot the cathode lines carry the decoded segment pattern of the lit digit.

The host never times the display. It writes the data word whenever it likes and reads the same word back. A new value is held back until the next slot boundary, so the digit that is lit never changes part-way through its slot. The drive polarity of both the anode and cathode lines is set by a parameter, and the slot length is a parameter sized for a 100 MHz fabric clock.

Top module: `segscan_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, anode select 0 is active (`anode_o` = 4'b1110 with active-low drive), the stored data is zero, `rd_data` reads 0 and the cathodes show the digit 0 (`cathode_o` = 7'h40 with active-low drive).
- R2: Exactly one anode is active at a time. On each slot boundary the active anode moves in the order select 0, 1, 2, 3 and then back to 0. With active-high drive these are the codes 0001, 0010, 0100, 1000.
- R3: Every slot lasts exactly `TICK_CYCLES` clock cycles. The default is 100,000 cycles at 100 MHz, which gives a full four-digit frame of 250 Hz. Elaboration rejects any setting whose frame rate is below 60 Hz.
- R4: While anode select i is active, the cathodes show the nibble at bits [4i+3:4i] of the displayed word.
- R5: Cathode bit 0 through bit 6 drive segments a through g. Values 0 to F use the usual hex glyphs; with active-high drive (g..a) these are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71.
- R6: The anode and cathode outputs change on the same clock edge. Neither output changes between slot boundaries.
- R7: A write is stored at once, but the displayed word takes the stored value only at the next slot boundary. The digit lit when the write occurs keeps its old pattern until its slot ends.
- R8: `rd_data` returns bits [15:0] of the most recent write in the cycle after that write. Bits [31:16] read 0. A write with `wr_en` low has no effect.
- R9: With `ACTIVE_LOW` = 1, an active anode and a lit segment drive 0. With `ACTIVE_LOW` = 0, both drive 1.
- R10: Raising `rst` in the middle of a scan returns the block to the R1 state. Scanning then restarts at anode select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the data word |
| wr_data | input | 32 | Write data; bits [15:0] hold the four digit nibbles |
| rd_data | output | 32 | Read-back of the stored data word, upper bits zero |
| anode_o | output | 4 | Digit select lines, one active at a time |
| cathode_o | output | 7 | Segment lines a..g for the lit digit |

## Verification
The bench first writes a new word in the middle of a slot and checks that the lit digit keeps its old glyph until the slot ends. A design that loads the display at once would show a half-slot flash of the new value. The bench also measures the cycles between anode changes to catch an off-by-one divider. It runs every hex value through each anode position, so a swapped nibble order or a wrong glyph table shows up as a wrong pattern on a named digit. Finally, a reset in the middle of a scan and a second instance with the opposite polarity expose a pointer that does not restart, and an inversion that was applied to only one output group.

// File: rtl/segscan_pkg.sv
package segscan_pkg;
   localparam int DIGITS  = 4;
   localparam int NIB_W   = 4;
   localparam int SEG_W   = 7;
   localparam int IDX_W   = $clog2(DIGITS);

   typedef logic [SEG_W-1:0] seg_t;
   typedef logic [NIB_W-1:0] nib_t;
   typedef logic [IDX_W-1:0] idx_t;
endpackage

// File: rtl/segscan_timer.sv
module segscan_timer #(
   parameter int TICK_CYCLES = 100000
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   if (TICK_CYCLES < 1) begin : g_bad_tick
      $error("segscan_timer: TICK_CYCLES must be at least 1");
   end

   if (TICK_CYCLES == 1) begin : g_every
      assign tick = ~rst;
   end else begin : g_count
      localparam int CNT_W = $clog2(TICK_CYCLES);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk) begin
         if (rst)              cnt <= '0;
         else if (cnt == LAST) cnt <= '0;
         else                  cnt <= cnt + 1'b1;
      end

      assign tick = ~rst && (cnt == LAST);

      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
         tick |=> !tick); // R3
   end
endmodule

// File: rtl/segscan_seq.sv
module segscan_seq
   import segscan_pkg::*;
#(
   parameter int N = DIGITS
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   output idx_t         idx,
   output logic [N-1:0] sel
);
   if (N != DIGITS) begin : g_bad_n
      $error("segscan_seq: digit count is fixed by the package");
   end

   localparam idx_t LAST_IDX = idx_t'(N - 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         sel <= N'(1);
         idx <= '0;
      end else if (adv) begin
         sel <= {sel[N-2:0], sel[N-1]};
         idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
      end
   end

   AST_ANODE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot(sel)); // R2
   AST_ANODE_ROTATE: assert property (@(posedge clk) disable iff (rst)
      adv |=> sel == {$past(sel[N-2:0]), $past(sel[N-1])}); // R2
   AST_ANODE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(sel)); // R6
   AST_IDX_MATCH: assert property (@(posedge clk) disable iff (rst)
      sel[idx]); // R4
endmodule

// File: rtl/segscan_regs.sv
module segscan_regs
   import segscan_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    wr_en,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic                    slot_adv,
   output logic [DATA_W-1:0]       rd_data,
   output logic [DIGITS*NIB_W-1:0] disp_word
);
   localparam int STORE_W = DIGITS * NIB_W;

   if (DATA_W < STORE_W) begin : g_bad_width
      $error("segscan_regs: DATA_W too narrow for the digit nibbles");
   end

   logic [STORE_W-1:0] held;

   always_ff @(posedge clk) begin
      if (rst) begin
         held      <= '0;
         disp_word <= '0;
      end else begin
         if (wr_en)    held      <= wr_data[STORE_W-1:0];
         if (slot_adv) disp_word <= held;
      end
   end

   if (DATA_W > STORE_W) begin : g_pad
      assign rd_data = {{(DATA_W-STORE_W){1'b0}}, held};
   end else begin : g_exact
      assign rd_data = held;
   end

   AST_READBACK: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> rd_data[STORE_W-1:0] == $past(wr_data[STORE_W-1:0])); // R8
   AST_DISP_HOLD: assert property (@(posedge clk) disable iff (rst)
      !slot_adv |=> $stable(disp_word)); // R7
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      rd_data >> STORE_W == '0); // R8
endmodule

// File: rtl/segscan_hexdec.sv
module segscan_hexdec
   import segscan_pkg::*;
(
   input  nib_t nib,
   output seg_t seg
);
   always_comb begin
      unique case (nib)
         4'h0: seg = 7'h3F;
         4'h1: seg = 7'h06;
         4'h2: seg = 7'h5B;
         4'h3: seg = 7'h4F;
         4'h4: seg = 7'h66;
         4'h5: seg = 7'h6D;
         4'h6: seg = 7'h7D;
         4'h7: seg = 7'h07;
         4'h8: seg = 7'h7F;
         4'h9: seg = 7'h6F;
         4'hA: seg = 7'h77;
         4'hB: seg = 7'h7C;
         4'hC: seg = 7'h39;
         4'hD: seg = 7'h5E;
         4'hE: seg = 7'h79;
         default: seg = 7'h71;
      endcase
   end
endmodule

// File: rtl/segscan_ctrl.sv
module segscan_ctrl
   import segscan_pkg::*;
#(
   parameter int CLK_HZ      = 100_000_000,
   parameter int TICK_CYCLES = 100_000,
   parameter int DATA_W      = 32,
   parameter bit ACTIVE_LOW  = 1'b1,
   parameter int MIN_FRAME_HZ = 60
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [DIGITS-1:0] anode_o,
   output logic [SEG_W-1:0]  cathode_o
);
   localparam longint FRAME_CYC = longint'(TICK_CYCLES) * DIGITS;

   if (longint'(CLK_HZ) < FRAME_CYC * MIN_FRAME_HZ) begin : g_too_slow
      $error("segscan_ctrl: frame rate below the minimum refresh");
   end

   logic                    tick;
   idx_t                    idx;
   logic [DIGITS-1:0]       sel;
   logic [DIGITS*NIB_W-1:0] disp_word;
   nib_t                    nibs [DIGITS];
   seg_t                    seg_lit;

   segscan_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
      .clk(clk), .rst(rst), .tick(tick));

   segscan_seq #(.N(DIGITS)) u_seq (
      .clk(clk), .rst(rst), .adv(tick), .idx(idx), .sel(sel));

   segscan_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .slot_adv(tick), .rd_data(rd_data), .disp_word(disp_word));

   for (genvar d = 0; d < DIGITS; d++) begin : g_unpack
      assign nibs[d] = disp_word[d*NIB_W +: NIB_W];
   end

   segscan_hexdec u_dec (.nib(nibs[idx]), .seg(seg_lit));

   if (ACTIVE_LOW) begin : g_drive_low
      assign anode_o   = ~sel;
      assign cathode_o = ~seg_lit;
   end else begin : g_drive_high
      assign anode_o   = sel;
      assign cathode_o = seg_lit;
   end

   AST_LOCKSTEP: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(anode_o) && $stable(cathode_o)); // R6
   AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (rst)
      $countones(anode_o) == (ACTIVE_LOW ? DIGITS - 1 : 1)); // R9
endmodule

// File: tb/segscan_ctrl_test.sv
module segscan_ctrl_test;
   localparam int T = 8;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_lo, rd_hi;
   logic [3:0]  an_lo, an_hi;
   logic [6:0]  ca_lo, ca_hi;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   segscan_ctrl #(.CLK_HZ(100_000_000), .TICK_CYCLES(T), .ACTIVE_LOW(1'b1)) uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_lo), .anode_o(an_lo), .cathode_o(ca_lo));

   segscan_ctrl #(.CLK_HZ(100_000_000), .TICK_CYCLES(T), .ACTIVE_LOW(1'b0)) uut_pos (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_hi), .anode_o(an_hi), .cathode_o(ca_hi));

   // reference model built from the requirements
   int          k;
   logic [15:0] m_held, m_disp;
   always @(posedge clk) begin
      if (rst) begin
         k <= 0; m_held <= '0; m_disp <= '0;
      end else begin
         k <= k + 1;
         if (k % T == T - 1) m_disp <= m_held;
         if (wr_en) m_held <= wr_data[15:0];
      end
   end

   function automatic logic [6:0] glyph(input logic [3:0] v);
      case (v)
         4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
         4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
         4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
         4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
      endcase
   endfunction

   function automatic int cur_digit();
      return (k / T) % 4;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h (k=%0d)", req, act, exp, k);
      end
   endtask

   task automatic compare_now(input string req);
      logic [3:0] ea;
      logic [6:0] ec;
      ea = 4'b0001 << cur_digit();
      ec = glyph(m_disp[cur_digit()*4 +: 4]);
      check({req, " anode"},   {28'd0, an_lo}, {28'd0, ~ea});
      check({req, " cathode"}, {25'd0, ca_lo}, {25'd0, ~ec});
      check({req, " R9 anode+"},   {28'd0, an_hi}, {28'd0, ea});
      check({req, " R9 cathode+"}, {25'd0, ca_hi}, {25'd0, ec});
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic write_word(input logic [31:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 32'hDEAD_BEEF;
   endtask

   task automatic run_compare(input int cycles, input string req);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         compare_now(req);
      end
   endtask

   task automatic test_reset();
      do_reset();
      check("R1 anode",   {28'd0, an_lo}, 32'h0000_000E);
      check("R1 cathode", {25'd0, ca_lo}, 32'h0000_0040);
      check("R1 rd_data", rd_lo, 32'h0);
      check("R9 anode+ reset",   {28'd0, an_hi}, 32'h1);
      check("R9 cathode+ reset", {25'd0, ca_hi}, 32'h3F);
   endtask

   task automatic test_readback();
      write_word(32'hABCD_5E7F);
      check("R8 low half kept", rd_lo, 32'h0000_5E7F);
      check("R8 second instance", rd_hi, 32'h0000_5E7F);
      write_word(32'hFFFF_0000);
      check("R8 upper ignored", rd_lo, 32'h0);
      @(negedge clk);
      wr_data = 32'h0000_1111;
      @(negedge clk);
      check("R8 no strobe no change", rd_lo, 32'h0);
   endtask

   task automatic test_order();
      logic [3:0] codes [5];
      codes = '{4'b1110, 4'b1101, 4'b1011, 4'b0111, 4'b1110};
      do_reset();
      for (int s = 0; s < 5; s++) begin
         while (k != s * T) @(negedge clk);
         check("R2 rotation code", {28'd0, an_lo}, {28'd0, codes[s]});
      end
   endtask

   task automatic test_slot_len();
      logic [3:0] prev;
      int cnt;
      prev = an_lo;
      while (an_lo == prev) @(negedge clk);
      prev = an_lo; cnt = 0;
      while (an_lo == prev) begin @(negedge clk); cnt++; end
      check("R3 slot length", cnt, T);
   endtask

   task automatic test_hex();
      logic [15:0] pats [4];
      pats = '{16'h3210, 16'h7654, 16'hBA98, 16'hFEDC};
      do_reset();
      foreach (pats[p]) begin
         write_word({16'h0, pats[p]});
         run_compare(5 * T, "R4 R5 R6");
      end
   endtask

   task automatic test_defer();
      logic [6:0] c0;
      do_reset();
      write_word(32'h1111);
      while (!(k >= T && k % T == 2)) @(negedge clk);
      c0 = ca_lo;
      check("R7 old glyph before write", {25'd0, c0}, {25'd0, ~glyph(4'h1)});
      write_word(32'h8888);
      check("R7 readback immediate", rd_lo, 32'h8888);
      while (k % T != 0) begin
         check("R7 lit digit held", {25'd0, ca_lo}, {25'd0, c0});
         @(negedge clk);
      end
      check("R7 new glyph at boundary", {25'd0, ca_lo}, {25'd0, ~glyph(4'h8)});
   endtask

   task automatic test_mid_reset();
      write_word(32'hFFFF);
      repeat (2 * T + 3) @(negedge clk);
      do_reset();
      check("R10 anode restart", {28'd0, an_lo}, 32'hE);
      check("R10 cathode zero",  {25'd0, ca_lo}, 32'h40);
      check("R10 data cleared",  rd_lo, 32'h0);
      run_compare(2 * T, "R10 R2");
   endtask

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      test_reset();
      test_readback();
      test_order();
      test_slot_len();
      test_hex();
      test_defer();
      test_mid_reset();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule